// File: doc/BRIEF.md
# Processor Tick Timer with Match Modes

This block is a tick timer placed next to a processor core. Software reaches it through a simple port that writes and reads registers. It keeps two registers. The first is a 32-bit count register. The second is a control register that holds:

- a compare period,
- a pending flag,
- an interrupt-enable bit,
- a 2-bit operating mode.

While the timer is active, the count advances by one on every clock cycle in which the tick-enable input is high.

On each advance the low period-width bits of the incremented count are compared with the period. A match can set the pending flag and raise the interrupt line. What the counter does after a match depends on the mode:

- it is cleared and counts on,
- it freezes until software touches the timer again, or
- it keeps incrementing and wraps through the full 32-bit range.

Software can only keep or clear the pending flag through the control register; it can never set it.

Top module: `tick_timer`

## Requirements
- R1: After reset the count register reads 0, the control register reads 0 and `irq` is low.
- R2: Control register bits 31:30 hold the mode. 00 = off, 01 = restart, 10 = one-shot, 11 = free-running. In mode 00 the count does not change on tick cycles.
- R3: In any mode other than 00 (and not halted), the count increases by exactly 1 on each cycle with `tickEn` high, and is unchanged on cycles with `tickEn` low.
- R4: A match occurs when bits 27:0 of the incremented count equal the period field (control bits 27:0). Count bits 31:28 play no part.
- R5: In restart mode a match clears the count to 0, and counting continues from there.
- R6: In one-shot mode the count stops at the matching value. Later ticks leave it unchanged until software writes the count or the control register.
- R7: In free-running mode the count keeps incrementing past a match and wraps from 0xFFFFFFFF to 0.
- R8: On a match, the pending flag (control bit 28) is set only when interrupt-enable (control bit 29) is 1. `irq` is high exactly while pending and interrupt-enable are both 1.
- R9: A control write with bit 28 = 1 leaves the pending flag unchanged. A control write with bit 28 = 0 clears it, which drops `irq`.
- R10: A count write (`wrSel` = 0) loads `wrData` into the count. Counting then continues on ticks unless the mode is 00.
- R11: When a count write and a match fall in the same cycle, the written value is loaded. When a match and a pending-clearing control write fall in the same cycle, the pending flag ends up set.
- R12: `rdData` returns the count when `rdSel` = 0. It returns {mode, interrupt-enable, pending, period} (bits 31:30, 29, 28, 27:0) when `rdSel` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Advance the count this cycle |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = count, 1 = control |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read source: 0 = count, 1 = control |
| rdData | output | 32 | Read data (combinational) |
| irq | output | 1 | Timer interrupt, high while pending and enabled |

## Verification
The assertions assume that `tickEn`, `wrEn`, `wrSel` and `wrData` are known values after reset and change only between clock edges. They also assume that one write per cycle targets exactly one register. The stimulus meets these conditions: every input is changed a short delay after a rising edge and held through the next edge. The collision cases are built by raising `tickEn` together with a single write, so the match and the write share one edge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_FREE    = 2'b11
  } tmrMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // load count from write data
    logic clr;    // clear count
    logic inc;    // advance count
    logic perLd;  // load period field
  } dpStrobe_t;

endpackage

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic [PER_W-1:0] period,
  output logic             cmpEq
);

  logic [CNT_W-1:0] nextCnt;

  assign nextCnt = cnt + 1'b1;
  // Match looks only at the period-width slice of the advanced count
  assign cmpEq   = (nextCnt[PER_W-1:0] == period);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.load) begin
      cnt <= wrData;
    end else if (strb.clr) begin
      cnt <= '0;
    end else if (strb.inc) begin
      cnt <= nextCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      period <= '0;
    end else if (strb.perLd) begin
      period <= wrData[PER_W-1:0];
    end
  end

endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             cmpEq,
  output dpStrobe_t        strb,
  output tmrMode_e         mode,
  output logic             ieQ,
  output logic             pendQ,
  output logic             haltedQ,
  output logic             hit
);

  localparam int MODE_LSB = CNT_W - 2;
  localparam int IE_BIT   = CNT_W - 3;
  localparam int PEND_BIT = CNT_W - 4;

  logic cntWr, ctlWr, running, step;

  assign cntWr   = wrEn && !wrSel;
  assign ctlWr   = wrEn &&  wrSel;
  assign running = (mode != MODE_OFF) && !haltedQ;
  assign step    = tickEn && running;
  assign hit     = step && cmpEq;

  always_comb begin
    strb.load  = cntWr;
    strb.clr   = !cntWr && hit && (mode == MODE_RESTART);
    strb.inc   = !cntWr && step && !strb.clr;
    strb.perLd = ctlWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= MODE_OFF;
      ieQ  <= 1'b0;
    end else if (ctlWr) begin
      mode <= tmrMode_e'(wrData[MODE_LSB +: 2]);
      ieQ  <= wrData[IE_BIT];
    end
  end

  // Match-driven set outranks a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (hit && ieQ) begin
      pendQ <= 1'b1;
    end else if (ctlWr && !wrData[PEND_BIT]) begin
      pendQ <= 1'b0;
    end
  end

  // One-shot stop; any software write releases it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltedQ <= 1'b0;
    end else if (wrEn) begin
      haltedQ <= 1'b0;
    end else if (hit && (mode == MODE_ONESHOT)) begin
      haltedQ <= 1'b1;
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic             irq
);

  localparam int PER_W = CNT_W - 4;

  dpStrobe_t        strb;
  tmrMode_e         mode;
  logic             ieQ, pendQ, haltedQ, hit, cmpEq;
  logic [CNT_W-1:0] cnt;
  logic [PER_W-1:0] period;

  tick_timer_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .cmpEq(cmpEq), .strb(strb), .mode(mode), .ieQ(ieQ),
    .pendQ(pendQ), .haltedQ(haltedQ), .hit(hit)
  );

  tick_timer_dp #(.CNT_W(CNT_W), .PER_W(PER_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .cnt(cnt), .period(period), .cmpEq(cmpEq)
  );

  assign rdData = rdSel ? {mode, ieQ, pendQ, period} : cnt;
  assign irq    = pendQ && ieQ;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             wrEn,
  input logic             wrSel,
  input logic [CNT_W-1:0] wrData,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input tmrMode_e         mode,
  input logic             ieQ,
  input logic             pendQ,
  input logic             haltedQ,
  input logic             hit
);

  localparam int PEND_BIT = CNT_W - 4;

  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF && !(wrEn && !wrSel)) |=> $stable(cnt));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrEn) |=> $stable(cnt));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && mode == MODE_RESTART && !(wrEn && !wrSel)) |=> (cnt == '0));

  // R6
  oneshot_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haltedQ && !wrEn) |=> $stable(cnt));

  // R8
  pend_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pendQ && !(tickEn && ieQ)) |=> !pendQ);

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && !wrData[PEND_BIT] && !tickEn) |=> !irq);

  // R10
  count_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (cnt == $past(wrData)));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
  .wrData(wrData), .irq(irq), .cnt(cnt), .mode(mode), .ieQ(ieQ),
  .pendQ(pendQ), .haltedQ(haltedQ), .hit(hit)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;
  logic        irq;

  int applied = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] val;
    logic        irqExp;
    string       tag;
  } item_t;

  item_t expQ[$];
  event  smpEv;

  always #10 clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .irq(irq)
  );

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(smpEv);
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        applied++;
        if (rdData !== it.val || irq !== it.irqExp) begin
          fails++;
          $display("FAIL %s: rdData=%h irq=%b expected rdData=%h irq=%b",
                   it.tag, rdData, irq, it.val, it.irqExp);
        end
      end
    end
  end

  // All tasks start and end 2 ns after a rising edge
  task automatic wr(input logic sel, input logic [31:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(posedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(posedge clk);
    #2;
    tickEn = 1'b0;
  endtask

  task automatic wrTick(input logic sel, input logic [31:0] d);
    tickEn = 1'b1; wrEn = 1'b1; wrSel = sel; wrData = d;
    @(posedge clk); #2;
    tickEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic expect_rd(input logic sel, input logic [31:0] v,
                           input logic ir, input string tag);
    item_t it;
    rdSel = sel;
    it.val = v; it.irqExp = ir; it.tag = tag;
    expQ.push_back(it);
    #1;
    ->smpEv;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rstN = 1'b1;
    // R1 reset state
    expect_rd(0, 32'h0, 0, "R1 count after reset");
    expect_rd(1, 32'h0, 0, "R1 control after reset");

    // R2 off mode ignores ticks; R10 load works while off
    wr(0, 32'd5);
    ticks(3);
    expect_rd(0, 32'd5, 0, "R2 off mode holds count");

    // R5 restart mode, period 4, irq enabled
    wr(0, 32'd0);
    wr(1, 32'h6000_0004);
    ticks(3);
    expect_rd(0, 32'd3, 0, "R3 one per tick");
    ticks(1);
    expect_rd(0, 32'd0, 1, "R5 cleared on match, R8 irq raised");
    expect_rd(1, 32'h7000_0004, 1, "R12 control readback with pending");
    ticks(2);
    expect_rd(0, 32'd2, 1, "R5 counting on after restart");

    // R9 pending keep / clear
    wr(1, 32'h7000_0004);
    expect_rd(1, 32'h7000_0004, 1, "R9 write with bit28=1 keeps pending");
    wr(1, 32'h6000_0004);
    expect_rd(1, 32'h6000_0004, 0, "R9 write with bit28=0 clears pending");

    // R8 match without enable leaves pending clear
    wr(1, 32'h4000_0004);
    ticks(2);
    expect_rd(0, 32'd0, 0, "R8 match with ie=0 no pending");
    expect_rd(1, 32'h4000_0004, 0, "R8 pending stays 0");

    // R6 one-shot, period 3
    wr(0, 32'd0);
    wr(1, 32'hA000_0003);
    ticks(5);
    expect_rd(0, 32'd3, 1, "R6 one-shot frozen at match");
    wr(0, 32'd10);
    ticks(2);
    expect_rd(0, 32'd12, 1, "R10 count write resumes counting");

    // R4 upper bits ignored, R7 free-running continues
    wr(1, 32'hE000_0002);
    wr(0, 32'h5000_0000);
    expect_rd(0, 32'h5000_0000, 0, "R10 load value");
    ticks(2);
    expect_rd(0, 32'h5000_0002, 1, "R4 match with upper bits set");
    ticks(1);
    expect_rd(0, 32'h5000_0003, 1, "R7 keeps counting past match");

    // R7 wrap
    wr(1, 32'hE000_0000);
    wr(0, 32'hFFFF_FFFF);
    ticks(1);
    expect_rd(0, 32'h0, 1, "R7 wrap to zero and match");
    ticks(1);
    expect_rd(0, 32'h1, 1, "R7 after wrap");

    // R11 collisions
    wr(1, 32'hE000_0005);
    wr(0, 32'd4);
    wrTick(0, 32'd100);
    expect_rd(0, 32'd100, 1, "R11 count write beats match");
    wr(1, 32'hE000_0005);
    wr(0, 32'd4);
    expect_rd(0, 32'd4, 0, "R11 setup cleared");
    wrTick(1, 32'hE000_0005);
    expect_rd(1, 32'hF000_0005, 1, "R11 match set beats clear");
    expect_rd(0, 32'd5, 1, "R11 count advanced on collision");

    // R2 writing mode 00 stops counting
    wr(1, 32'h0000_0005);
    ticks(3);
    expect_rd(0, 32'd5, 0, "R2 stopped after mode 00 write");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule